// File: doc/BRIEF.md
# Masked Vector Gather with Per-Element Mask Retirement

This block loads up to eight 32-bit elements from memory addresses that are computed per element. Each address is formed from a shared base, a 64-bit index for that element, a scale and a signed displacement. A write mask picks which elements are loaded. A separate flag ignores the mask and loads every active element. The active element count is 2, 4 or 8.

Reads go out one at a time over a valid/ready request channel and come back on a response channel. Each successful response is written into its lane of the destination vector, and the element's mask bit is cleared at once. If an error response arrives, the sequence stops. The mask then lists only the elements still to be loaded, so issuing the same operation again finishes the work without repeating the loads that already completed.

An operation starts with a one-cycle `start` pulse while the block is idle. All operands are captured on that pulse. The caller waits for the `done` pulse and then reads `dst_out`, `mask_out` and `fault`.

Top module: `vgather_unit`

## Requirements
- R1: The address for element j is base_addr + (index j << scale_sel) + disp, taken modulo 2^64. The scale codes 0, 1, 2 and 3 multiply by 1, 2, 4 and 8. Index j occupies index_vec[64j+63:64j].
- R2: cnt_sel codes 0, 1, 2 and 3 select 2, 4, 8 and 8 active elements. An active element j is requested exactly when mask_in[j] is 1 or no_mask is 1. No element at or above the count is ever requested.
- R3: Requests are issued in ascending element order. A new request is never raised while a response is outstanding.
- R4: An error-free response for element j writes its data to dst_out[32j+31:32j] and clears mask bit j. This also happens in no-mask mode.
- R5: Lanes below the count that are not loaded keep their dst_in value.
- R6: When the operation completes without error, mask bits at or above the count read 0 and dst_out bits at or above 32×count read 0.
- R7: An error response stops the sequence and sets fault. Lanes and mask bits already retired stay as they are. The failing lane and every later lane keep their previous value and mask bit. The upper-lane clearing of R6 is not applied, and no further request is issued.
- R8: done is high for exactly one cycle at the end of an operation. busy is high from the cycle after start until done. fault is cleared when a new operation starts.
- R9: After reset, busy, done, fault, mem_req_valid, mask_out and dst_out are all 0.
- R10: While mem_req_valid is high and mem_req_ready is low, the request stays valid and its address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| cnt_sel | input | 2 | Element count code (2/4/8/8) |
| scale_sel | input | 2 | Index shift amount (x1/x2/x4/x8) |
| no_mask | input | 1 | Load every active element regardless of mask |
| base_addr | input | 64 | Common base address |
| disp | input | 64 | Displacement added to every address (two's complement) |
| index_vec | input | 512 | Eight 64-bit element indices |
| mask_in | input | 8 | Initial element mask |
| dst_in | input | 256 | Initial destination vector |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_addr | output | 64 | Read request address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |
| mem_rsp_err | input | 1 | Read response is an error |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last operation stopped on an error |
| dst_out | output | 256 | Destination vector |
| mask_out | output | 8 | Remaining element mask |

## Verification
The test cases cover several patterns:
- A full mask at count 8 checks both the scaled address arithmetic and the strict ascending order.
- A sparse mask at count 4, with stray upper mask bits set and a negative displacement, separates "skip this lane" from "clear this lane". It also shows that the stray bits are dropped.
- No-mask mode with an all-zero mask shows that the override works and that it still retires mask bits.
- An all-zero mask checks that no request is issued at all.
- An error in the middle of a full mask, followed by a re-run from the returned mask, shows that only the outstanding elements are fetched the second time.
- An error on the very first element shows that nothing is retired and the upper lanes are left alone.

Request and response delays vary between cases, so a request has to wait on a low ready signal.

// File: rtl/vg_pkg.sv
package vg_pkg;

    typedef enum logic [1:0] {
        VG_IDLE  = 2'd0,
        VG_ISSUE = 2'd1,
        VG_WAIT  = 2'd2
    } vg_state_e;

    // Number of active elements selected by the count code.
    function automatic logic [3:0] vg_lanes_of(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd2;
            2'd1:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/vg_lowest_pick.sv
module vg_lowest_pick #(
    parameter int N   = 8,
    parameter int IXW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req,
    output logic           any,
    output logic [IXW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IXW'(i);
        end
    end

    // R3
    pick_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[idx]);

    // R3
    pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((req & ((N'(1) << idx) - N'(1))) == '0));

endmodule

// File: rtl/vg_ea_calc.sv
module vg_ea_calc #(
    parameter int AW = 64,
    parameter int IW = 64
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] index,
    input  logic [1:0]    scale_sel,
    input  logic [AW-1:0] disp,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] scaled;

    always_comb begin
        scaled = AW'(index) << scale_sel;
        addr   = base + scaled + disp;
    end

endmodule

// File: rtl/vg_lane_merge.sv
module vg_lane_merge #(
    parameter int LANES = 8,
    parameter int DW    = 32,
    parameter int LIXW  = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0] cur,
    input  logic                wr_en,
    input  logic [LIXW-1:0]     wr_lane,
    input  logic [DW-1:0]       wr_data,
    input  logic [LANES-1:0]    keep,
    output logic [LANES*DW-1:0] nxt
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign nxt[l*DW +: DW] = (wr_en && (wr_lane == LIXW'(l))) ? wr_data :
                                 (keep[l] ? cur[l*DW +: DW] : '0);
    end

endmodule

// File: rtl/vgather_unit.sv
module vgather_unit #(
    parameter int LANES = 8,
    parameter int DW    = 32,
    parameter int IW    = 64,
    parameter int AW    = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          cnt_sel,
    input  logic [1:0]          scale_sel,
    input  logic                no_mask,
    input  logic [AW-1:0]       base_addr,
    input  logic [AW-1:0]       disp,
    input  logic [LANES*IW-1:0] index_vec,
    input  logic [LANES-1:0]    mask_in,
    input  logic [LANES*DW-1:0] dst_in,
    output logic                mem_req_valid,
    output logic [AW-1:0]       mem_req_addr,
    input  logic                mem_req_ready,
    input  logic                mem_rsp_valid,
    input  logic [DW-1:0]       mem_rsp_data,
    input  logic                mem_rsp_err,
    output logic                busy,
    output logic                done,
    output logic                fault,
    output logic [LANES*DW-1:0] dst_out,
    output logic [LANES-1:0]    mask_out
);
    import vg_pkg::*;

    localparam int LIXW = $clog2(LANES);

    typedef struct packed {
        vg_state_e           st;
        logic [LANES-1:0]    pend;
        logic [LANES-1:0]    mask;
        logic [LANES-1:0]    live;
        logic [LANES*DW-1:0] dst;
        logic [LIXW-1:0]     cur;
        logic [1:0]          scl;
        logic [AW-1:0]       base;
        logic [AW-1:0]       disp;
        logic [LANES*IW-1:0] idx;
        logic                done;
        logic                fault;
    } vg_regs_t;

    vg_regs_t s_q, s_d;

    logic                any_pend;
    logic [LIXW-1:0]     pick_idx;
    logic [AW-1:0]       ea;
    logic [LANES-1:0]    live_w;
    logic                mrg_wr;
    logic [LANES-1:0]    mrg_keep;
    logic [LANES*DW-1:0] mrg_out;

    vg_lowest_pick #(.N(LANES), .IXW(LIXW)) i_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (s_q.pend),
        .any   (any_pend),
        .idx   (pick_idx)
    );

    vg_ea_calc #(.AW(AW), .IW(IW)) i_ea (
        .base      (s_q.base),
        .index     (s_q.idx[int'(pick_idx)*IW +: IW]),
        .scale_sel (s_q.scl),
        .disp      (s_q.disp),
        .addr      (ea)
    );

    // Merge control depends only on registered state and response inputs.
    always_comb begin
        mrg_wr   = (s_q.st == VG_WAIT) && mem_rsp_valid && !mem_rsp_err;
        mrg_keep = ((s_q.st == VG_ISSUE) && !any_pend) ? s_q.live : '1;
    end

    vg_lane_merge #(.LANES(LANES), .DW(DW), .LIXW(LIXW)) i_merge (
        .cur     (s_q.dst),
        .wr_en   (mrg_wr),
        .wr_lane (s_q.cur),
        .wr_data (mem_rsp_data),
        .keep    (mrg_keep),
        .nxt     (mrg_out)
    );

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            live_w[l] = (l < int'(vg_lanes_of(cnt_sel)));
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            VG_IDLE: begin
                if (start) begin
                    s_d.st    = VG_ISSUE;
                    s_d.live  = live_w;
                    s_d.pend  = no_mask ? live_w : (mask_in & live_w);
                    s_d.mask  = mask_in;
                    s_d.dst   = dst_in;
                    s_d.scl   = scale_sel;
                    s_d.base  = base_addr;
                    s_d.disp  = disp;
                    s_d.idx   = index_vec;
                    s_d.fault = 1'b0;
                end
            end
            VG_ISSUE: begin
                if (!any_pend) begin
                    s_d.dst  = mrg_out;
                    s_d.mask = s_q.mask & s_q.live;
                    s_d.done = 1'b1;
                    s_d.st   = VG_IDLE;
                end else if (mem_req_ready) begin
                    s_d.cur = pick_idx;
                    s_d.st  = VG_WAIT;
                end
            end
            VG_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        s_d.fault = 1'b1;
                        s_d.done  = 1'b1;
                        s_d.st    = VG_IDLE;
                    end else begin
                        s_d.dst             = mrg_out;
                        s_d.mask[s_q.cur]   = 1'b0;
                        s_d.pend[s_q.cur]   = 1'b0;
                        s_d.st              = VG_ISSUE;
                    end
                end
            end
            default: s_d.st = VG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_req_valid = (s_q.st == VG_ISSUE) && any_pend;
    assign mem_req_addr  = ea;
    assign busy          = (s_q.st != VG_IDLE);
    assign done          = s_q.done;
    assign fault         = s_q.fault;
    assign dst_out       = s_q.dst;
    assign mask_out      = s_q.mask;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4
    mask_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != VG_IDLE) |=> ((s_q.mask & ~$past(s_q.mask)) == '0));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    fault_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == VG_WAIT) && mem_rsp_valid && mem_rsp_err) |=> (!busy && fault && done));

    // R6
    finish_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> ((mask_out & ~s_q.live) == '0));

endmodule

// File: tb/test_vgather_unit.sv
`timescale 1ns/1ps
module test_vgather_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   cnt_sel = '0;
    logic [1:0]   scale_sel = '0;
    logic         no_mask = 1'b0;
    logic [63:0]  base_addr = '0;
    logic [63:0]  disp = '0;
    logic [511:0] index_vec = '0;
    logic [7:0]   mask_in = '0;
    logic [255:0] dst_in = '0;
    logic         mem_req_valid;
    logic [63:0]  mem_req_addr;
    logic         mem_req_ready = 1'b0;
    logic         mem_rsp_valid = 1'b0;
    logic [31:0]  mem_rsp_data = '0;
    logic         mem_rsp_err = 1'b0;
    logic         busy, done, fault;
    logic [255:0] dst_out;
    logic [7:0]   mask_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int          rdy_gap = 0;
    int          lat = 0;
    bit          fault_on = 0;
    logic [63:0] fault_addr = '0;
    logic [63:0] exp_q[$];

    always #2.5 clk = ~clk;

    vgather_unit i_vgather_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_sel(cnt_sel),
        .scale_sel(scale_sel), .no_mask(no_mask), .base_addr(base_addr),
        .disp(disp), .index_vec(index_vec), .mask_in(mask_in), .dst_in(dst_in),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .busy(busy), .done(done), .fault(fault),
        .dst_out(dst_out), .mask_out(mask_out)
    );

    function automatic logic [31:0] memval(input logic [63:0] a);
        return (a[31:0] * 32'h9E37_79B1) ^ a[63:32] ^ 32'h0BAD_F00D;
    endfunction

    function automatic int count_of(input logic [1:0] c);
        return (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : 8;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [255:0] act,
                         input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: memory model that pops expected addresses and compares.
    initial begin
        forever begin
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (rst_n && mem_req_valid) begin
                logic [63:0] a;
                logic [63:0] e;
                a = mem_req_addr;
                repeat (rdy_gap) @(negedge clk);
                check(mem_req_valid && (mem_req_addr == a), "R10 request held",
                      256'(mem_req_addr), 256'(a));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 R3 unexpected request", 256'(a), 256'(0));
                end else begin
                    e = exp_q.pop_front();
                    check(a == e, "R1 R3 address/order", 256'(a), 256'(e));
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (lat) @(negedge clk);
                check(!mem_req_valid, "R3 single outstanding", 256'(mem_req_valid), 256'(0));
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = memval(a);
                mem_rsp_err   = fault_on && (a == fault_addr);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
            end
        end
    end

    // Driver: builds operands, predicts results, pushes expected addresses.
    task automatic run_case(input string nm, input logic [1:0] c, input logic [1:0] s,
                            input bit nm_f, input logic [63:0] b, input logic [63:0] d,
                            input logic [7:0] m, input logic [255:0] di, input int seed,
                            input int flane, input int gap, input int l);
        logic [255:0] edst;
        logic [7:0]   emask;
        bit           efault;
        int           n;
        int           w;
        n = count_of(c);
        for (int j = 0; j < 8; j++)
            index_vec[64*j +: 64] = (64'(seed) * 64'(j + 3)) ^ (64'(j) << 20);
        edst = di; emask = m; efault = 0; fault_on = 0;
        exp_q.delete();
        for (int j = 0; j < n; j++) begin
            if (!efault && (nm_f || m[j])) begin
                logic [63:0] a;
                a = b + (index_vec[64*j +: 64] << s) + d;
                if (j == flane) begin
                    fault_on = 1; fault_addr = a; efault = 1;
                    exp_q.push_back(a);
                end else begin
                    exp_q.push_back(a);
                    edst[32*j +: 32] = memval(a);
                    emask[j] = 1'b0;
                end
            end
        end
        if (!efault) begin
            for (int j = n; j < 8; j++) begin
                emask[j] = 1'b0;
                edst[32*j +: 32] = '0;
            end
        end
        rdy_gap = gap; lat = l;
        @(negedge clk);
        cnt_sel = c; scale_sel = s; no_mask = nm_f; base_addr = b; disp = d;
        mask_in = m; dst_in = di; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {"R8 busy after start ", nm}, 256'(busy), 256'(1));
        w = 0;
        while (!done && w < 400) begin
            @(negedge clk);
            w++;
        end
        check(done == 1'b1, {"R8 done reached ", nm}, 256'(done), 256'(1));
        check(dst_out == edst, {"R4 R5 R6 R7 dst ", nm}, dst_out, edst);
        check(mask_out == emask, {"R4 R6 R7 mask ", nm}, 256'(mask_out), 256'(emask));
        check(fault == efault, {"R7 R8 fault flag ", nm}, 256'(fault), 256'(efault));
        check(exp_q.size() == 0, {"R2 all requests seen ", nm},
              256'(exp_q.size()), 256'(0));
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, {"R8 done single cycle ", nm},
              256'({done, busy}), 256'(0));
    endtask

    function automatic logic [255:0] pat(input int seed);
        logic [255:0] v;
        for (int j = 0; j < 8; j++) v[32*j +: 32] = 32'hD000_0000 | (32'(seed) << 8) | 32'(j);
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9
        check(!busy && !done && !fault && !mem_req_valid, "R9 reset controls",
              256'({busy, done, fault, mem_req_valid}), 256'(0));
        check(mask_out == 0 && dst_out == 0, "R9 reset data",
              dst_out ^ 256'(mask_out), 256'(0));

        run_case("full8",     2'd2, 2'd3, 0, 64'h1000_0000, 64'd16,
                 8'hFF, pat(1), 11, -1, 0, 0);
        run_case("sparse4",   2'd1, 2'd1, 0, 64'h2000_0000, -64'sd64,
                 8'hFA, pat(2), 23, -1, 1, 2);
        run_case("nomask2",   2'd0, 2'd0, 1, 64'h3000_0000, 64'd4,
                 8'h00, pat(3), 37, -1, 0, 1);
        run_case("fault_mid", 2'd2, 2'd2, 0, 64'h4000_0000, 64'd0,
                 8'hFF, pat(4), 41, 2, 2, 0);
        begin
            logic [255:0] kept;
            logic [7:0]   km;
            kept = dst_out; km = mask_out;
            run_case("rerun",  2'd2, 2'd2, 0, 64'h4000_0000, 64'd0,
                     km, kept, 41, -1, 0, 1);
        end
        run_case("empty",     2'd3, 2'd0, 0, 64'h5000_0000, 64'd8,
                 8'h00, pat(6), 53, -1, 0, 0);
        run_case("fault_first", 2'd1, 2'd3, 0, 64'h6000_0000, 64'd32,
                 8'h3F, pat(7), 67, 0, 1, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule